// File: doc/BRIEF.md
# Transmit Self-Test Character Source

This block sits in front of the serializer of one transmit channel and chooses what that channel sends. In normal operation it registers the 10-bit character from the user and passes it on one character clock later. When the self-test enable is high, it ignores the user character. It then sends a fixed pseudo-random sequence of 511 characters that repeats without end. A receiver with the same generator can rebuild the sequence and compare it against what arrives.

The sequence comes from a 9-bit maximal-length shift register. Each time self-test is switched on, the register starts again from all ones. Each transmitted character is the register state with an even-parity bit above it. A one-cycle marker goes with each character that starts the sequence, so a receiver, or a bench, can align to it. A synchronous active-low reset turns self-test off and clears the outputs.

Top module: `txpat_source`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, that edge clears `tx_char` to 0 and `seq_start` to 0, and clears the internal self-test enable register.
- R2: While self-test is off, `tx_char` at each edge takes the value `user_char` had at that edge, and `seq_start` stays 0.
- R3: `bist_en` is registered. If it is first sampled high at edge k, then edge k still passes the user character, and edge k+1 sends the seed character 10'h3FF with `seq_start` = 1.
- R4: While self-test runs, the state advances once per clock as s' = {s[7:0], s[8]^s[4]}, which is the polynomial x^9 + x^5 + 1. Each character sent is {^s, s}: bit 9 is the XOR of state bits 8..0, so every pattern character has even parity over its 10 bits.
- R5: The sequence repeats every 511 characters and visits 511 distinct 9-bit states. `seq_start` is 1 exactly on the characters equal to the seed, 10'h3FF, and 0 on every other character.
- R6: While self-test is active, the value on `user_char` has no effect on `tx_char` or `seq_start`.
- R7: If `bist_en` is sampled low at edge d, edge d+1 sends `user_char` again. A later enable restarts the sequence from the seed.
- R8: A reset while self-test runs forces it off. Once reset is released with `bist_en` held high, the first edge passes the user character, and the sequence then restarts from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bist_en | input | 1 | Self-test enable level |
| user_char | input | 10 | Character from the user path |
| tx_char | output | 10 | Character to the serializer |
| seq_start | output | 1 | High on the first character of each sequence pass |

## Verification
The hardest situation to reach is the wrap from the last state back to the seed, 511 characters after the start. Only there can the bench see that the period is right and that the marker does not fire early. The enable task keeps self-test on for one full pass plus one character. Throughout the pass it changes `user_char` on every cycle, and it keeps a bench model of the state so it can check every character, the marker on each cycle and that every state is distinct. Reset during a running sequence and a mid-sequence disable with re-enable are each driven by their own task, and both show a clean restart at the seed.

// File: rtl/txpat_pkg.sv
// Package: shared widths and constants for the transmit self-test source.
// Assumes the character is exactly one bit wider than the generator state.
package txpat_pkg;
    localparam int LFSR_W   = 9;
    localparam int CHAR_W   = LFSR_W + 1;
    localparam int TAP_HI   = 9;
    localparam int TAP_LO   = 5;
    localparam int SEQ_LEN  = (1 << LFSR_W) - 1;

    typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/txpat_enable_reg.sv
// Module: registers the self-test enable level once per character clock.
// Assumes the enable is a quasi-static level that is already synchronous to clk.
// Reset forces the registered enable to zero, so self-test is off.
module txpat_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_q
);
    // Capture the enable level; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_in;
    end
endmodule

// File: rtl/txpat_lfsr.sv
// Module: Fibonacci shift-register generator with two feedback taps.
// While run is low the state is held at the all-ones seed. While run is high it
// shifts left one place per clock, and the tap XOR enters at bit 0.
// Assumes TAP_HI = W and the taps give a maximal-length polynomial.
module txpat_lfsr #(
    parameter int W      = 9,
    parameter int TAP_HI = 9,
    parameter int TAP_LO = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] state,
    output logic         at_seed
);
    localparam logic [W-1:0] SEED = '1;

    logic feedback;
    logic [W-1:0] nxt;

    // Feedback bit from the two polynomial taps.
    assign feedback = state[TAP_HI-1] ^ state[TAP_LO-1];

    // Next state: shift toward the MSB and insert the feedback bit.
    always_comb begin
        nxt = {state[W-2:0], feedback};
    end

    // Hold the seed while idle or in reset; advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) state <= SEED;
        else                state <= nxt;
    end

    // Flag the seed state so the output stage can mark the start of a pass.
    assign at_seed = (state == SEED);
endmodule

// File: rtl/txpat_char_build.sv
// Module: forms a pattern character from the generator state by adding an
// even-parity bit above the state bits. Purely combinational.
// Assumes CW = W + 1.
module txpat_char_build #(
    parameter int W  = 9,
    parameter int CW = 10
) (
    input  logic [W-1:0]  state,
    output logic [CW-1:0] pat_char
);
    logic [W-1:0] chain;

    // Running XOR across the state bits; the top of the chain is the parity.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_par
            if (gi == 0) begin : g_first
                assign chain[gi] = state[gi];
            end else begin : g_rest
                assign chain[gi] = chain[gi-1] ^ state[gi];
            end
        end
    endgenerate

    // Parity bit above the state bits.
    assign pat_char = {chain[W-1], state};
endmodule

// File: rtl/txpat_out_stage.sv
// Module: output register. It selects the pattern character or the user
// character and registers the start-of-sequence marker.
// Assumes sel_pat is the registered enable. The user path has one cycle of latency.
module txpat_out_stage #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_pat,
    input  logic [CW-1:0] pat_char,
    input  logic          pat_first,
    input  logic [CW-1:0] user_char,
    output logic [CW-1:0] tx_char,
    output logic          seq_start
);
    logic [CW-1:0] mux_char;

    // Choose between the test pattern and user data.
    always_comb begin
        mux_char = sel_pat ? pat_char : user_char;
    end

    // Register the chosen character and the marker; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_char   <= '0;
            seq_start <= 1'b0;
        end else begin
            tx_char   <= mux_char;
            seq_start <= sel_pat & pat_first;
        end
    end
endmodule

// File: rtl/txpat_source.sv
// Module: transmit self-test character source for one channel (top level).
// While the enable is off it passes the user character with one cycle of latency.
// While the enable is on it sends a 511-character pseudo-random sequence that
// starts at the all-ones seed, together with a start-of-pass marker.
// Assumes a single character clock and a synchronous active-low reset.
module txpat_source
    import txpat_pkg::*;
#(
    parameter int STATE_W = LFSR_W,
    parameter int OUT_W   = CHAR_W,
    parameter int FB_HI   = TAP_HI,
    parameter int FB_LO   = TAP_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bist_en,
    input  logic [OUT_W-1:0] user_char,
    output logic [OUT_W-1:0] tx_char,
    output logic             seq_start
);
    logic               bist_on;
    logic [STATE_W-1:0] lfsr_state;
    logic               lfsr_at_seed;
    logic [OUT_W-1:0]   pat_char;

    // Registered enable; cleared by reset.
    txpat_enable_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .en_in (bist_en),
        .en_q  (bist_on)
    );

    // Pattern generator; reseeded whenever self-test is off.
    txpat_lfsr #(
        .W      (STATE_W),
        .TAP_HI (FB_HI),
        .TAP_LO (FB_LO)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (bist_on),
        .state   (lfsr_state),
        .at_seed (lfsr_at_seed)
    );

    // State plus parity bit forms the pattern character.
    txpat_char_build #(
        .W  (STATE_W),
        .CW (OUT_W)
    ) u_build (
        .state    (lfsr_state),
        .pat_char (pat_char)
    );

    // Output select and register.
    txpat_out_stage #(
        .CW (OUT_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_pat   (bist_on),
        .pat_char  (pat_char),
        .pat_first (lfsr_at_seed),
        .user_char (user_char),
        .tx_char   (tx_char),
        .seq_start (seq_start)
    );
endmodule

// Checker: temporal properties of the self-test source, bound to the top.
module txpat_source_chk #(
    parameter int W  = 9,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bist_on,
    input logic [CW-1:0] user_char,
    input logic [CW-1:0] tx_char,
    input logic          seq_start
);
    localparam int PERIOD = (1 << W) - 1;
    localparam logic [CW-1:0] SEED_CHAR = {^{W{1'b1}}, {W{1'b1}}};

    logic [W:0] gap;
    logic       seen_start;

    // Count characters since the last marker, for checking the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !bist_on) begin
            gap        <= '0;
            seen_start <= 1'b0;
        end else if (seq_start) begin
            gap        <= 1;
            seen_start <= 1'b1;
        end else begin
            gap        <= gap + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (tx_char == '0) && !seq_start);

    // R2
    user_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bist_on |=> (tx_char == $past(user_char)) && !seq_start);

    // R4
    lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_on && $past(bist_on)) |=>
            tx_char[W-1:0] == {$past(tx_char[W-2:0]),
                               $past(tx_char[W-1]) ^ $past(tx_char[4])});

    // R4
    even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bist_on) |-> (^tx_char) == 1'b0);

    // R5
    start_is_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> (tx_char == SEED_CHAR) && $past(bist_on));

    // R5
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && seen_start) |-> (gap == PERIOD[W:0]));
endmodule

bind txpat_source txpat_source_chk #(
    .W  (STATE_W),
    .CW (OUT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bist_on   (bist_on),
    .user_char (user_char),
    .tx_char   (tx_char),
    .seq_start (seq_start)
);

// File: tb/txpat_source_tb.sv
// Directed bench for the transmit self-test source: one task per scenario.
module txpat_source_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bist_en = 1'b0;
    logic [9:0] user_char = '0;
    logic [9:0] tx_char;
    logic       seq_start;

    int n_checks = 0;
    int n_fails  = 0;

    txpat_source dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bist_en   (bist_en),
        .user_char (user_char),
        .tx_char   (tx_char),
        .seq_start (seq_start)
    );

    always #2.5 clk = ~clk;

    // Reference next state: x^9 + x^5 + 1, shift toward the MSB.
    function automatic logic [8:0] ref_next(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    function automatic logic [9:0] ref_char(input logic [8:0] s);
        return {^s, s};
    endfunction

    // Wait for the next edge and settle 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [9:0] act_c, input logic act_s,
                         input logic [9:0] exp_c, input logic exp_s);
        n_checks++;
        if (act_c !== exp_c || act_s !== exp_s) begin
            n_fails++;
            $display("FAIL %s: tx_char=%h seq_start=%b expected tx_char=%h seq_start=%b",
                     req, act_c, act_s, exp_c, exp_s);
        end
    endtask

    // R1: outputs cleared while reset is held.
    task automatic t_reset();
        rst_n = 1'b0; bist_en = 1'b0; user_char = 10'h2C5;
        step(); step();
        check("R1", tx_char, seq_start, 10'h000, 1'b0);
        rst_n = 1'b1;
    endtask

    // R2: user data passes with one cycle latency while self-test is off.
    task automatic t_passthru();
        logic [9:0] pats [6] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h001, 10'h200};
        bist_en = 1'b0;
        foreach (pats[i]) begin
            user_char = pats[i];
            step();
            check("R2", tx_char, seq_start, pats[i], 1'b0);
        end
    endtask

    // R3, R4, R5, R6: one full pass plus the wrap, with user data changing every cycle.
    task automatic t_enable_seq();
        logic [8:0] s;
        bit seen [0:511];
        int distinct;
        int bad;
        distinct = 0;
        bad = 0;
        foreach (seen[i]) seen[i] = 1'b0;
        bist_en = 1'b1; user_char = 10'h0F0;
        step();
        check("R3 enable edge still user", tx_char, seq_start, 10'h0F0, 1'b0);
        user_char = 10'h00F;
        step();
        s = 9'h1FF;
        check("R3 seed first", tx_char, seq_start, 10'h3FF, 1'b1);
        seen[s] = 1'b1; distinct = 1;
        for (int i = 1; i <= 511; i++) begin
            user_char = 10'((i * 37) ^ 10'h2A5);
            step();
            s = ref_next(s);
            if (i < 511) begin
                if (!seen[s]) distinct++;
                seen[s] = 1'b1;
            end
            if (tx_char !== ref_char(s) || seq_start !== (i == 511)) bad++;
            if (i == 5 || i == 200 || i == 510)
                check("R4 R6 pattern step", tx_char, seq_start, ref_char(s), 1'b0);
        end
        check("R5 wrap to seed", tx_char, seq_start, 10'h3FF, 1'b1);
        check("R5 distinct states", 10'(distinct), 1'b0, 10'd511, 1'b0);
        check("R4 R5 R6 full pass mismatches", 10'(bad), 1'b0, 10'd0, 1'b0);
        user_char = 10'h3C3;
        step();
        check("R5 after wrap", tx_char, seq_start, ref_char(ref_next(9'h1FF)), 1'b0);
    endtask

    // R7: disable returns to user data; re-enable restarts at the seed.
    task automatic t_disable_reenable();
        bist_en = 1'b0; user_char = 10'h111;
        step();
        user_char = 10'h222;
        step();
        check("R7 user restored", tx_char, seq_start, 10'h222, 1'b0);
        bist_en = 1'b1; user_char = 10'h333;
        step();
        check("R7 enable edge", tx_char, seq_start, 10'h333, 1'b0);
        step();
        check("R7 restart seed", tx_char, seq_start, 10'h3FF, 1'b1);
        step();
        check("R7 restart second", tx_char, seq_start, ref_char(ref_next(9'h1FF)), 1'b0);
    endtask

    // R8: reset while running forces self-test off; restart follows release.
    task automatic t_reset_active();
        bist_en = 1'b1;
        step(); step(); step();
        rst_n = 1'b0; user_char = 10'h0AB;
        step();
        check("R8 reset clears", tx_char, seq_start, 10'h000, 1'b0);
        rst_n = 1'b1; user_char = 10'h1CD;
        step();
        check("R8 off after release", tx_char, seq_start, 10'h1CD, 1'b0);
        step();
        check("R8 restart seed", tx_char, seq_start, 10'h3FF, 1'b1);
        bist_en = 1'b0;
        step();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        #1;
        t_reset();
        t_passthru();
        t_enable_seq();
        t_disable_reenable();
        t_reset_active();
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end
endmodule